// File: doc/BRIEF.md
# Programmable Serial Bit-Clock Divider

This block produces the bit clock for a serial engine. It divides a chosen input clock by a programmable 8-bit value. It runs entirely in the system clock domain. When the source-select input is high, every system clock cycle counts as one input tick. When it is low, an external clock pin is passed through a two-flop synchronizer and an edge detector. Each rising edge seen on that pin then counts as one tick.

On every tick, a phase counter steps through one output period of (divide + 1) ticks. The divided level is high for the first part of the period and low for the rest. Together with the level, the block gives two single-cycle enables. One marks the cycle in which the level first reads high, and the other marks the cycle in which it first reads low. A serial engine uses these enables to launch and capture data without clocking from the divided signal. A divide value written at any time is taken up only when the current period ends, so a change never produces a clipped phase.

Top module: `sclk_divider`

## Requirements
- R1: With a nonzero divide value D, the output period is exactly D + 1 ticks, and the rise enable pulses once per period.
- R2: For an even nonzero D, the high phase lasts D/2 + 1 ticks and the low phase lasts D/2 ticks.
- R3: For an odd D, the high and low phases each last (D + 1)/2 ticks.
- R4: When `src_sys` is 1, every system clock cycle is a tick. With D = 1, the output therefore toggles at half the system clock rate: high one cycle, low one cycle.
- R5: When `src_sys` is 0, each rising edge of `ext_clk` is one tick, and falling edges are not ticks. The outputs respond at the second rising system clock edge after the edge that first samples `ext_clk` high.
- R6: A divide value of 0 is bypass. On every tick, both `sclk_rise` and `sclk_fall` pulse and `sclk_out` is held at 1.
- R7: `div_val` is sampled only on the tick that ends the current period. A change made in mid-period leaves the running period untouched.
- R8: `sclk_rise` and `sclk_fall` last one cycle. Each appears in the same cycle as the level change it marks, and neither appears in a cycle that follows a non-tick cycle.
- R9: While `rst_n` is sampled low, `sclk_out`, `sclk_rise` and `sclk_fall` are 0, the counter is cleared and the synchronizer is cleared. The first tick after reset begins a new period and takes up the current `div_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sys | input | 1 | 1: system clock is the tick source; 0: external pin |
| ext_clk | input | 1 | External clock, asynchronous to `clk` |
| div_val | input | 8 | Divide value D; period is D + 1 ticks, 0 is bypass |
| sclk_out | output | 1 | Divided clock level |
| sclk_rise | output | 1 | One-cycle enable in the cycle the level first reads high |
| sclk_fall | output | 1 | One-cycle enable in the cycle the level first reads low |

## Verification
The two functions that collide are the end of a period and a change of the divide value. When both fall on the same tick, the new value must be loaded and must also set the level of the first cycle of the new period. The random phase changes `div_val` on arbitrary cycles, including bypass and the largest values, so some changes land exactly on the boundary tick and others land in mid-period. A cycle-exact bench model is compared against all three outputs on every cycle. It is built from the period and width rules, and it loads the divide value only at its own period end.

// File: rtl/sclk_div_pkg.sv
// Package: shared widths, types and the phase-width rule of the serial
// bit-clock divider. Assumes the divide value is an unsigned integer.
package sclk_div_pkg;

    localparam int DIV_WIDTH   = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [DIV_WIDTH-1:0] div_t;

    // Ticks spent high in one period for divide value d.
    // Even d gives d/2 + 1 and odd d gives (d + 1)/2; both equal floor(d/2) + 1.
    function automatic div_t high_ticks(input div_t d);
        div_t half;
        half = d >> 1;
        return half + div_t'(1);
    endfunction

endpackage

// File: rtl/sclk_ext_sync.sv
// Module: brings the asynchronous external clock into the system domain
// through a STAGES-deep flop chain. It gives one single-cycle pulse for each
// rising edge seen. Assumes the external clock high and low times each last
// at least one system clock period.
module sclk_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic edge_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the pin into the synchronizer, plus one extra flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN-2:0], ext_in};
    end

    // Rising edge seen at the synchronized output.
    always_comb edge_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R5: an edge pulse never lasts two cycles.
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/sclk_tick_sel.sv
// Module: picks the tick source. A set select bit makes every system cycle a
// tick. A clear select bit uses the synchronized external edge. Assumes the
// select input is quasi-static or synchronous to the system clock.
module sclk_tick_sel (
    input  logic use_sys,
    input  logic ext_edge,
    output logic tick
);
    // Tick source multiplexer.
    always_comb tick = use_sys ? 1'b1 : ext_edge;

endmodule

// File: rtl/sclk_phase_gen.sv
// Module: counts ticks through one output period and registers the level
// and the two edge enables. It loads a new divide value only at a period
// end, and it treats a divide value of 0 as bypass. Assumes tick is a
// single-cycle enable in the system clock domain.
module sclk_phase_gen
    import sclk_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  div_t div_req,
    output logic lvl_q,
    output logic rise_q,
    output logic fall_q
);
    div_t cnt_q, act_q;
    div_t cnt_d, act_d;
    logic at_end, byp_d, lvl_d;

    // Next counter, active divide value and level, as they will be after a tick.
    always_comb begin
        at_end = (cnt_q == act_q);
        act_d  = at_end ? div_req : act_q;
        cnt_d  = at_end ? '0 : cnt_q + div_t'(1);
        byp_d  = (act_d == '0);
        lvl_d  = byp_d ? 1'b1 : (cnt_d < high_ticks(act_d));
    end

    // State and output registers, advanced only on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= '0;
            lvl_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= cnt_d;
            act_q  <= act_d;
            lvl_q  <= lvl_d;
            rise_q <= byp_d | (lvl_d & ~lvl_q);
            fall_q <= byp_d | (~lvl_d & lvl_q);
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end
    end

    // R1: the counter never runs past the active period end.
    assert_cnt_in_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= act_q);

    // R7: the active divide value changes only on a period-end tick.
    assert_load_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && at_end) |=> $stable(act_q));

    // R8: no enable follows a cycle without a tick.
    assert_no_stb_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!rise_q && !fall_q));

    // R8: a lone rise enable marks a 0 to 1 change of the level.
    assert_rise_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q && !fall_q) |-> (lvl_q && !$past(lvl_q)));

    // R8: a lone fall enable marks a 1 to 0 change of the level.
    assert_fall_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q && !rise_q) |-> (!lvl_q && $past(lvl_q)));

    // R6: both enables together occur only in bypass, where the level is high.
    assert_bypass_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q && fall_q) |-> (lvl_q && act_q == '0));

endmodule

// File: rtl/sclk_divider.sv
// Module: top of the serial bit-clock divider. It selects a tick source
// (the system clock, or the synchronized external clock) and divides the
// tick rate by div_val + 1. It outputs the divided level and one-cycle
// rise and fall enables. Assumes everything downstream runs on clk.
module sclk_divider
    import sclk_div_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 src_sys,
    input  logic                 ext_clk,
    input  logic [DIV_WIDTH-1:0] div_val,
    output logic                 sclk_out,
    output logic                 sclk_rise,
    output logic                 sclk_fall
);
    logic ext_edge;
    logic tick;

    sclk_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_in     (ext_clk),
        .edge_pulse (ext_edge)
    );

    sclk_tick_sel u_sel (
        .use_sys  (src_sys),
        .ext_edge (ext_edge),
        .tick     (tick)
    );

    sclk_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .div_req (div_val),
        .lvl_q   (sclk_out),
        .rise_q  (sclk_rise),
        .fall_q  (sclk_fall)
    );

    // R9: the cycle after reset is sampled, all outputs are low.
    assert_reset_low_R9: assert property (@(posedge clk)
        !rst_n |=> (!sclk_out && !sclk_rise && !sclk_fall));

    // R4: with the system source and a nonzero level, the enables follow every cycle's tick.
    assert_sys_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sys && $past(src_sys) && $rose(sclk_out)) |-> sclk_rise);

endmodule

// File: tb/sclk_divider_test.sv
// Bench: a cycle-exact model built from the requirements is compared on
// every cycle. Stimulus is directed corners plus seeded random sequences.
module sclk_divider_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sys = 1'b1;
    logic       ext_clk = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       sclk_out, sclk_rise, sclk_fall;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic       m_s1, m_s2, m_s3;
    logic [7:0] m_cnt, m_act;
    logic       m_lvl, m_rise, m_fall;

    always #10 clk = ~clk;

    sclk_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sys   (src_sys),
        .ext_clk   (ext_clk),
        .div_val   (div_val),
        .sclk_out  (sclk_out),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    // High width from the even/odd rules in R2 and R3.
    function automatic int exp_high(input int d);
        if (d % 2 == 0) return d / 2 + 1;
        return (d + 1) / 2;
    endfunction

    // Advance the model by one rising edge.
    task automatic model_edge(input logic r, input logic s, input logic e, input logic [7:0] d);
        logic t, lv;
        logic [7:0] na, nc;
        if (!r) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_cnt = 0; m_act = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
        end else begin
            t = s ? 1'b1 : (m_s2 & ~m_s3);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = e;
            if (t) begin
                if (m_cnt == m_act) begin na = d; nc = 0; end
                else begin na = m_act; nc = m_cnt + 8'd1; end
                if (na == 0) begin
                    m_rise = 1; m_fall = 1; lv = 1;
                end else begin
                    lv = (int'(nc) < exp_high(int'(na)));
                    m_rise = lv & ~m_lvl;
                    m_fall = ~lv & m_lvl;
                end
                m_lvl = lv; m_act = na; m_cnt = nc;
            end else begin
                m_rise = 0; m_fall = 0;
            end
        end
    endtask

    // Apply inputs on the falling edge, then compare after the rising edge.
    task automatic step(input logic r, input logic s, input logic e,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        rst_n = r; src_sys = s; ext_clk = e; div_val = d;
        @(posedge clk);
        model_edge(r, s, e, d);
        #1;
        checks++;
        if (sclk_out !== m_lvl || sclk_rise !== m_rise || sclk_fall !== m_fall) begin
            fails++;
            $display("FAIL %s: out/rise/fall=%b%b%b expected %b%b%b (div=%0d src=%b)",
                     tag, sclk_out, sclk_rise, sclk_fall, m_lvl, m_rise, m_fall, d, s);
        end
    endtask

    // Measure one full period and its high time with the system source.
    task automatic measure(input int d, input string tag);
        int n, hi, guard;
        guard = 0;
        do begin step(1, 1, 0, 8'(d), tag); guard++; end
        while (!sclk_rise && guard < 600);
        n = 0; hi = 0;
        do begin
            step(1, 1, 0, 8'(d), tag);
            n++;
            if (sclk_out && !sclk_rise) hi++;
        end while (!sclk_rise && n < 600);
        hi++;
        checks++;
        if (n != d + 1 || hi != exp_high(d)) begin
            fails++;
            $display("FAIL %s: div=%0d period=%0d high=%0d expected period=%0d high=%0d",
                     tag, d, n, hi, d + 1, exp_high(d));
        end
    endtask

    initial begin
        logic e;
        logic s;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        // R9: reset state
        for (int i = 0; i < 4; i++) step(0, 1, 0, 8'd3, "R9");
        // R4: system clock, divide 1 gives half rate
        for (int i = 0; i < 30; i++) step(1, 1, 0, 8'd1, "R4");
        measure(1, "R4");
        // R1 / R2 / R3: period and width checks
        measure(9, "R1");
        measure(8, "R2");
        measure(2, "R2");
        measure(7, "R3");
        measure(255, "R3");
        measure(254, "R2");
        // R6: bypass
        for (int i = 0; i < 20; i++) step(1, 1, 0, 8'd0, "R6");
        // R7: change in mid-period
        for (int i = 0; i < 3; i++) step(1, 1, 0, 8'd6, "R7");
        for (int i = 0; i < 30; i++) step(1, 1, 0, 8'd3, "R7");
        for (int i = 0; i < 2; i++)  step(1, 1, 0, 8'd10, "R7");
        for (int i = 0; i < 30; i++) step(1, 1, 0, 8'd0, "R7");
        // R5: external source with random high/low times
        e = 0; d = 8'd2;
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(2) == 0) e = ~e;
            if ($urandom_range(40) == 0) d = 8'($urandom_range(5));
            step(1, 0, e, d, "R5");
        end
        // R9: reset in mid-run, with ext high at release
        for (int i = 0; i < 3; i++) step(0, 0, 1, 8'd4, "R9");
        for (int i = 0; i < 40; i++) step(1, 0, (i % 6) < 3, 8'd4, "R9");
        // R8 / R1: random mix of sources and divide changes
        s = 1; e = 0; d = 8'd5;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(49) == 0) s = ~s;
            if ($urandom_range(1) == 0) e = ~e;
            if ($urandom_range(7) == 0)
                d = ($urandom_range(9) == 0) ? 8'($urandom_range(255)) : 8'($urandom_range(12));
            step(1, s, e, d, "R8");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule